// File: doc/BRIEF.md
# LIN Master Frame Sequencer

This block runs one LIN master frame at a time from a three-part descriptor: an identifier byte, a length byte and a six-bit control word. It exchanges whole bytes with a serial bit engine that sits beside it. It first raises a break request and waits for the engine to acknowledge it. It then hands over the sync byte and the protected identifier. After the header, the frame goes one of two ways. In a transmit frame, the sequencer forwards payload bytes from a data port and appends the integrity bytes. In a receive frame, it takes the slave's bytes from the engine, passes the payload on, and checks the integrity bytes.

Two integrity mechanisms are available, and a frame may use both. The first is a modulo-256 checksum, sent inverted. The second is a 16-bit CRC. When both are on, the CRC comes before the checksum. A coverage flag decides whether the protected identifier is counted along with the payload. A legacy length mode takes the payload length from the identifier instead of the length byte. Identifiers in the top group of four are reported as command/extended frames.

Top module: `lin_frame_seq`

## Requirements
- R1: After reset the block is idle. desc_ready is 1, and brk_req, tx_valid, done, rxd_valid, csum_err, crc_err and ext_frame are all 0.
- R2: A descriptor is accepted on a cycle where desc_valid and desc_ready are both high. From the next cycle, brk_req stays high, with tx_valid low, until brk_ack is seen. The engine is then offered 0x55, followed by the protected identifier.
- R3: When control bit 4 is set, the identifier bits 5:0 are sent with bit 6 = id0^id1^id2^id4 and bit 7 = ~(id1^id3^id4^id5). When bit 4 is clear, all eight descriptor bits are sent unchanged.
- R4: ext_frame is 1 exactly when identifier bits 5:0 lie in 0x3C..0x3F. It is loaded when a descriptor is accepted and holds until the next acceptance.
- R5: When control bit 5 is set, identifier bits 5:4 give the payload length: 00 and 01 give 2 bytes, 10 gives 4 and 11 gives 8. In that case the length byte is ignored. When bit 5 is clear, the length byte gives 0 to 255 payload bytes, and 0 means no payload.
- R6: When control bit 3 is 1 (transmit), each payload byte passes from dat_in to tx_byte. A byte moves when dat_in_valid, dat_in_ready and tx_ready are all high in the same cycle, and the bytes keep their order.
- R7: When control bit 1 is set, a checksum byte is placed after the payload. Its value is the one's complement of the modulo-256 sum of the covered bytes.
- R8: When control bit 0 is set, the protected identifier is covered by both the checksum and the CRC. When bit 0 is clear, only payload bytes are covered. Integrity bytes never cover one another.
- R9: When control bit 2 is set, two CRC bytes (CRC-16, polynomial 0x1021, initial value 0xFFFF, MSB first) are placed after the payload, high byte first. If the checksum is also enabled, the CRC bytes come before the checksum byte.
- R10: When control bit 3 is 0 (receive), only the header is sent. Each payload byte arriving on rx_valid/rx_byte appears on rxd_valid/rxd_byte one cycle later. Integrity bytes are compared and are not passed on.
- R11: A received checksum mismatch sets csum_err, and a received CRC mismatch sets crc_err. Both flags stay set until the next descriptor is accepted, and they clear on that acceptance.
- R12: done pulses for one cycle, in the cycle after the last byte of the frame is transferred. In that same cycle the block is idle again with desc_ready high.
- R13: While a header or integrity byte is offered and tx_ready is low, tx_valid stays high and tx_byte does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| desc_valid | input | 1 | Descriptor present |
| desc_ready | output | 1 | Sequencer idle, descriptor taken when valid |
| desc_id | input | 8 | Identifier byte (parity in 7:6) |
| desc_len | input | 8 | Payload length byte |
| desc_ctrl | input | 6 | 0 cover header, 1 checksum, 2 CRC, 3 transmit, 4 auto parity, 5 legacy length |
| brk_req | output | 1 | Break request to bit engine |
| brk_ack | input | 1 | Break finished |
| tx_valid | output | 1 | Byte offered to bit engine |
| tx_ready | input | 1 | Bit engine takes the byte |
| tx_byte | output | 8 | Byte to send |
| rx_valid | input | 1 | Byte received by bit engine |
| rx_byte | input | 8 | Received byte |
| dat_in_valid | input | 1 | Payload byte available for transmit |
| dat_in_ready | output | 1 | Payload byte consumed |
| dat_in | input | 8 | Payload byte for transmit |
| rxd_valid | output | 1 | Received payload byte strobe |
| rxd_byte | output | 8 | Received payload byte |
| ext_frame | output | 1 | Current identifier is a command/extended frame |
| csum_err | output | 1 | Sticky checksum mismatch |
| crc_err | output | 1 | Sticky CRC mismatch |
| done | output | 1 | Frame complete pulse |

## Verification
The bench covers several cases where a design could drop a byte or place one wrongly. A zero-length frame must go straight from the identifier to the integrity bytes, or to done. A design that decrements before testing would instead send 256 payload bytes. A frame with both CRC and checksum would expose a swapped order, or a checksum that folds in the CRC bytes. Frames with header coverage on and off would expose an identifier that is always or never summed. Tx_ready is stalled every third cycle, so a byte that slips while waiting would show as a wrong value. Legacy length from identifier bits, a 255-byte payload, and corrupted CRC and checksum bytes on receive are also run. These catch a length latched from the wrong field, a truncated counter, and error flags that fail to set, set under the wrong name, or clear before the next descriptor.

// File: rtl/lin_seq_pkg.sv
package lin_seq_pkg;

    localparam int CTL_W  = 6;
    localparam int C_HDR  = 0;
    localparam int C_CSUM = 1;
    localparam int C_CRC  = 2;
    localparam int C_TX   = 3;
    localparam int C_APAR = 4;
    localparam int C_LEG  = 5;

    localparam logic [7:0] SYNC_PATTERN = 8'h55;

    typedef enum logic [3:0] {
        S_IDLE,
        S_BRK,
        S_SYNC,
        S_PID,
        S_TXD,
        S_RXD,
        S_CRCH,
        S_CRCL,
        S_CSUM
    } seq_st_e;

    typedef struct packed {
        seq_st_e    st;
        logic [7:0] pid;
        logic [7:0] cnt;
        logic       hdr;
        logic       csum;
        logic       crc;
        logic       tx;
        logic       ext;
        logic       done;
        logic       rxv;
        logic [7:0] rxb;
        logic       csum_err;
        logic       crc_err;
    } seq_regs_t;

    typedef struct packed {
        logic [7:0]  sum;
        logic [15:0] crc;
    } acc_regs_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c,
                                             input logic [7:0]  b,
                                             input logic [15:0] poly);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ poly;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [1:0] lin_par(input logic [5:0] id);
        return {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4]};
    endfunction

endpackage

// File: rtl/lin_pid_gen.sv
module lin_pid_gen
    import lin_seq_pkg::*;
(
    input  logic [7:0] id_raw,
    input  logic       auto_par,
    output logic [7:0] pid,
    output logic       ext_id,
    output logic [7:0] legacy_len
);

    always_comb begin
        pid    = auto_par ? {lin_par(id_raw[5:0]), id_raw[5:0]} : id_raw;
        ext_id = (id_raw[5:2] == 4'hF);
        unique case (id_raw[5:4])
            2'b10:   legacy_len = 8'd4;
            2'b11:   legacy_len = 8'd8;
            default: legacy_len = 8'd2;
        endcase
    end

endmodule

// File: rtl/lin_integrity.sv
module lin_integrity
    import lin_seq_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] INIT = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [7:0]  sum_q,
    output logic [15:0] crc_q
);

    acc_regs_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d.sum = '0;
            acc_d.crc = INIT;
        end else if (upd) begin
            acc_d.sum = acc_q.sum + din;
            acc_d.crc = crc_step(acc_q.crc, din, POLY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q.sum <= '0;
            acc_q.crc <= INIT;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign sum_q = acc_q.sum;
    assign crc_q = acc_q.crc;

    // each frame starts its integrity values from the seeds (R7, R9)
    assert_clear_seeds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_q == 8'h00 && crc_q == INIT));

endmodule

// File: rtl/lin_frame_seq.sv
module lin_frame_seq
    import lin_seq_pkg::*;
#(
    parameter logic [15:0] CRC_POLY = 16'h1021,
    parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic [7:0]       desc_id,
    input  logic [7:0]       desc_len,
    input  logic [CTL_W-1:0] desc_ctrl,
    output logic             brk_req,
    input  logic             brk_ack,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_byte,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             dat_in_valid,
    output logic             dat_in_ready,
    input  logic [7:0]       dat_in,
    output logic             rxd_valid,
    output logic [7:0]       rxd_byte,
    output logic             ext_frame,
    output logic             csum_err,
    output logic             crc_err,
    output logic             done
);

    seq_regs_t   r_d, r_q;
    logic [7:0]  pid_w, leg_len_w;
    logic        ext_w;
    logic        acc_clr, acc_upd;
    logic [7:0]  acc_din, sum_w;
    logic [15:0] crc_w;
    logic        ev;
    logic [7:0]  int_byte;
    seq_st_e     after_crc, after_data, after_pid;

    lin_pid_gen u_pid (
        .id_raw     (desc_id),
        .auto_par   (desc_ctrl[C_APAR]),
        .pid        (pid_w),
        .ext_id     (ext_w),
        .legacy_len (leg_len_w)
    );

    lin_integrity #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .upd   (acc_upd),
        .din   (acc_din),
        .sum_q (sum_w),
        .crc_q (crc_w)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.rxv      = 1'b0;
        desc_ready   = 1'b0;
        brk_req      = 1'b0;
        tx_valid     = 1'b0;
        tx_byte      = '0;
        dat_in_ready = 1'b0;
        acc_clr      = 1'b0;
        acc_upd      = 1'b0;
        acc_din      = dat_in;
        ev           = 1'b0;
        int_byte     = '0;
        after_crc    = r_q.csum ? S_CSUM : S_IDLE;
        after_data   = r_q.crc ? S_CRCH : after_crc;
        after_pid    = (r_q.cnt != 8'd0) ? (r_q.tx ? S_TXD : S_RXD) : after_data;

        unique case (r_q.st)
            S_IDLE: begin
                desc_ready = 1'b1;
                if (desc_valid) begin
                    r_d.st       = S_BRK;
                    r_d.pid      = pid_w;
                    r_d.cnt      = desc_ctrl[C_LEG] ? leg_len_w : desc_len;
                    r_d.hdr      = desc_ctrl[C_HDR];
                    r_d.csum     = desc_ctrl[C_CSUM];
                    r_d.crc      = desc_ctrl[C_CRC];
                    r_d.tx       = desc_ctrl[C_TX];
                    r_d.ext      = ext_w;
                    r_d.csum_err = 1'b0;
                    r_d.crc_err  = 1'b0;
                    acc_clr      = 1'b1;
                end
            end
            S_BRK: begin
                brk_req = 1'b1;
                if (brk_ack) r_d.st = S_SYNC;
            end
            S_SYNC: begin
                tx_valid = 1'b1;
                tx_byte  = SYNC_PATTERN;
                if (tx_ready) r_d.st = S_PID;
            end
            S_PID: begin
                tx_valid = 1'b1;
                tx_byte  = r_q.pid;
                acc_din  = r_q.pid;
                if (tx_ready) begin
                    acc_upd = r_q.hdr;
                    r_d.st  = after_pid;
                end
            end
            S_TXD: begin
                tx_valid     = dat_in_valid;
                tx_byte      = dat_in;
                dat_in_ready = tx_ready;
                if (dat_in_valid && tx_ready) begin
                    acc_upd = 1'b1;
                    r_d.cnt = r_q.cnt - 8'd1;
                    if (r_q.cnt == 8'd1) r_d.st = after_data;
                end
            end
            S_RXD: begin
                acc_din = rx_byte;
                if (rx_valid) begin
                    acc_upd = 1'b1;
                    r_d.rxv = 1'b1;
                    r_d.rxb = rx_byte;
                    r_d.cnt = r_q.cnt - 8'd1;
                    if (r_q.cnt == 8'd1) r_d.st = after_data;
                end
            end
            default: begin
                if (r_q.st == S_CRCH)      int_byte = crc_w[15:8];
                else if (r_q.st == S_CRCL) int_byte = crc_w[7:0];
                else                       int_byte = ~sum_w;
                if (r_q.tx) begin
                    tx_valid = 1'b1;
                    tx_byte  = int_byte;
                    ev       = tx_ready;
                end else begin
                    ev = rx_valid;
                end
                if (ev) begin
                    if (!r_q.tx && rx_byte != int_byte) begin
                        if (r_q.st == S_CSUM) r_d.csum_err = 1'b1;
                        else                  r_d.crc_err  = 1'b1;
                    end
                    if (r_q.st == S_CRCH)      r_d.st = S_CRCL;
                    else if (r_q.st == S_CRCL) r_d.st = after_crc;
                    else                       r_d.st = S_IDLE;
                end
            end
        endcase

        if (r_d.st == S_IDLE && r_q.st != S_IDLE) r_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rxd_valid = r_q.rxv;
    assign rxd_byte  = r_q.rxb;
    assign ext_frame = r_q.ext;
    assign csum_err  = r_q.csum_err;
    assign crc_err   = r_q.crc_err;
    assign done      = r_q.done;

    assert_brk_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (!tx_valid && !dat_in_ready && !desc_ready));

    assert_hold_byte_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && r_q.st != S_TXD) |=> (tx_valid && $stable(tx_byte)));

    assert_csum_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (csum_err && !(desc_valid && desc_ready)) |=> csum_err);

    assert_crc_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !(desc_valid && desc_ready)) |=> crc_err);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> desc_ready);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/test_lin_frame_seq.sv
module test_lin_frame_seq;
    import lin_seq_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             desc_valid = 1'b0;
    logic             desc_ready;
    logic [7:0]       desc_id = '0;
    logic [7:0]       desc_len = '0;
    logic [CTL_W-1:0] desc_ctrl = '0;
    logic             brk_req;
    logic             brk_ack = 1'b0;
    logic             tx_valid;
    logic             tx_ready = 1'b0;
    logic [7:0]       tx_byte;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_byte = '0;
    logic             dat_in_valid = 1'b0;
    logic             dat_in_ready;
    logic [7:0]       dat_in = '0;
    logic             rxd_valid;
    logic [7:0]       rxd_byte;
    logic             ext_frame;
    logic             csum_err;
    logic             crc_err;
    logic             done;

    int n_run = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lin_frame_seq i_lin_frame_seq (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] x;
        bit          top;
        x = c;
        for (int k = 0; k < 8; k++) begin
            top = x[15] ^ b[7-k];
            x   = x << 1;
            if (top) x = x ^ 16'h1021;
        end
        return x;
    endfunction

    // bad: 0 clean, 1 corrupt first CRC byte, 2 corrupt checksum byte
    task automatic run_frame(input logic [7:0] id, input logic [7:0] len,
                             input logic [5:0] ctrl, input int bad, input int seed);
        logic [7:0]  pid, sum, expb, sb;
        logic [15:0] crc;
        logic [7:0]  data[$];
        logic [7:0]  integ[$];
        logic [7:0]  txq[$];
        logic [7:0]  rxq[$];
        bit          is_tx, hs, dh, rxe, last, fin, expv, stall, stall_prev, want_dh;
        int          nb, ti, di, ri, cyc;
        string       ph;

        is_tx = ctrl[3];
        pid   = id;
        if (ctrl[4]) begin
            pid[6] = id[0] ^ id[1] ^ id[2] ^ id[4];
            pid[7] = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        end
        if (ctrl[5]) nb = (id[5:4] == 2'b11) ? 8 : (id[5:4] == 2'b10) ? 4 : 2;
        else         nb = int'(len);
        sum = 8'h00;
        crc = 16'hFFFF;
        if (ctrl[0]) begin
            sum = sum + pid;
            crc = ref_crc(crc, pid);
        end
        for (int k = 0; k < nb; k++) begin
            data.push_back(8'((seed * 37 + k * 11 + 5) & 255));
            sum = sum + data[k];
            crc = ref_crc(crc, data[k]);
        end
        if (ctrl[2]) begin
            integ.push_back(crc[15:8]);
            integ.push_back(crc[7:0]);
        end
        if (ctrl[1]) integ.push_back(~sum);
        txq.push_back(8'h55);
        txq.push_back(pid);
        if (is_tx) begin
            foreach (data[k])  txq.push_back(data[k]);
            foreach (integ[k]) txq.push_back(integ[k]);
        end else begin
            foreach (data[k])  rxq.push_back(data[k]);
            foreach (integ[k]) rxq.push_back(integ[k]);
            if (bad == 1 && ctrl[2]) rxq[nb] = rxq[nb] ^ 8'h01;
            if (bad == 2 && ctrl[1]) rxq[rxq.size()-1] = rxq[rxq.size()-1] ^ 8'h80;
        end

        @(negedge clk);
        desc_id = id; desc_len = len; desc_ctrl = ctrl; desc_valid = 1'b1;
        #1;
        chk(desc_ready == 1'b1, "R12", "idle before accept", desc_ready, 1);
        @(posedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
        #1;
        chk(brk_req && !tx_valid, "R2", "break raised", brk_req, 1);
        chk(ext_frame == (id[5:2] == 4'hF), "R4", "extended flag", ext_frame, int'(id[5:2] == 4'hF));
        chk(!csum_err && !crc_err, "R11", "flags cleared on accept", {csum_err, crc_err}, 0);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(brk_req && !tx_valid, "R2", "break held without ack", {brk_req, tx_valid}, 2);
        brk_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        brk_ack = 1'b0;

        ti = 0; di = 0; ri = 0; cyc = 0; fin = 1'b0; stall_prev = 1'b0; sb = '0;
        while (!fin) begin
            tx_ready     = (cyc % 3 != 2);
            dat_in_valid = is_tx && di < nb && (cyc % 4 != 3);
            dat_in       = (di < nb) ? data[di] : 8'hEE;
            rx_valid     = !is_tx && ti >= 2 && ri < rxq.size() && (cyc % 2 == 0);
            rx_byte      = rx_valid ? rxq[ri] : 8'h00;
            #1;
            // R13: a stalled header or integrity byte stays put
            if (stall_prev) chk(tx_valid && tx_byte == sb, "R13", "byte held under stall", tx_byte, sb);
            hs  = tx_valid && tx_ready;
            dh  = dat_in_valid && dat_in_ready;
            rxe = rx_valid;
            stall = tx_valid && !tx_ready && !(is_tx && ti >= 2 && ti - 2 < nb);
            sb    = tx_byte;
            if (hs) begin
                if (ti == 0)                          ph = "R2";
                else if (ti == 1)                     ph = "R3";
                else if (ti - 2 < nb)                 ph = "R6";
                else if (ctrl[2] && ti - 2 - nb < 2)  ph = "R9";
                else if (ctrl[0])                     ph = "R8";
                else                                  ph = "R7";
                if (ti < txq.size()) chk(tx_byte == txq[ti], ph, "tx byte", tx_byte, txq[ti]);
                else                 chk(1'b0, "R12", "byte past end of frame", tx_byte, 0);
            end
            want_dh = hs && is_tx && ti >= 2 && ti - 2 < nb;
            chk(dh == want_dh, "R6", "payload handshake", dh, want_dh);
            expv = rxe && ri < nb;
            expb = rxe ? rxq[ri] : 8'h00;
            @(posedge clk);
            ti  = ti + int'(hs);
            di  = di + int'(dh);
            last = (hs || rxe) && ti == txq.size() && (is_tx || ri + int'(rxe) == rxq.size());
            @(negedge clk);
            #1;
            chk(rxd_valid == expv, "R10", "receive strobe", rxd_valid, expv);
            if (expv) chk(rxd_byte == expb, "R10", "receive byte", rxd_byte, expb);
            chk(done == last, "R12", "done timing", done, last);
            ri  = ri + int'(rxe);
            cyc = cyc + 1;
            stall_prev = stall;
            if (last) fin = 1'b1;
            if (cyc > 5000) begin
                chk(1'b0, "R12", "frame never completed", 0, 1);
                fin = 1'b1;
            end
        end
        tx_ready = 1'b0; dat_in_valid = 1'b0; rx_valid = 1'b0;

        chk(desc_ready == 1'b1, "R12", "idle after done", desc_ready, 1);
        chk(di == (is_tx ? nb : 0), "R5", "payload byte count", di, is_tx ? nb : 0);
        chk(csum_err == (bad == 2 && ctrl[1] && !is_tx), "R11", "checksum flag", csum_err,
            int'(bad == 2 && ctrl[1] && !is_tx));
        chk(crc_err == (bad == 1 && ctrl[2] && !is_tx), "R11", "CRC flag", crc_err,
            int'(bad == 1 && ctrl[2] && !is_tx));
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(csum_err == (bad == 2 && ctrl[1] && !is_tx) && crc_err == (bad == 1 && ctrl[2] && !is_tx),
            "R11", "flags sticky while idle", {csum_err, crc_err}, 0);
        chk(!done && desc_ready, "R12", "single done pulse", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(desc_ready && !brk_req && !tx_valid && !done && !rxd_valid && !csum_err
            && !crc_err && !ext_frame, "R1", "idle after reset",
            {desc_ready, brk_req, tx_valid, done, rxd_valid, csum_err, crc_err, ext_frame}, 8'h80);

        run_frame(8'h12, 8'd3,   6'b011011, 0, 1); // tx, checksum, header covered, auto parity
        run_frame(8'hC5, 8'd5,   6'b001110, 0, 2); // tx, CRC then checksum, parity verbatim (R3)
        run_frame(8'h2A, 8'h77,  6'b111010, 0, 3); // legacy length 4, length byte ignored (R5)
        run_frame(8'h05, 8'd0,   6'b001100, 0, 4); // tx, zero payload, CRC only
        run_frame(8'h21, 8'd4,   6'b010111, 0, 5); // rx, CRC+checksum, header covered
        run_frame(8'h3C, 8'd6,   6'b000101, 1, 6); // rx, extended id, bad CRC (R4, R11)
        run_frame(8'h3F, 8'd0,   6'b110011, 2, 7); // rx, legacy length 8, bad checksum
        run_frame(8'h3D, 8'd0,   6'b010000, 0, 8); // rx, no payload, no integrity
        run_frame(8'h10, 8'd255, 6'b001010, 0, 9); // tx, longest payload, checksum

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule